// File: doc/BRIEF.md
# UART Receive and Transmit FIFO Level Tracker

This block holds the two byte queues of a register-mapped UART. One queue buffers characters arriving from the deserializer until the host pops them. The other buffers characters the host writes until the serializer drains them. Each queue holds 64 bytes. The block keeps a fill count per queue. It reports the receive side as stored characters and the transmit side as free spaces, because those are the numbers host software polls for.

Each direction has a trigger flag with a programmable threshold. A 2-bit code in the control byte selects a coarse level. A 4-bit fine field, when nonzero, overrides that code with a level of four times its value. The control byte also carries the FIFO-enable bit and two self-clearing flush commands, one per queue. A sticky overrun flag records receive bytes lost to a full queue. A transmitter-disable input freezes draining while the host keeps filling.

Top module: `uart_fifo_levels`

## Requirements
- R1: Each queue holds 64 bytes. `rx_level` counts stored receive bytes and reads 0 after reset. `tx_space` equals 64 minus the stored transmit bytes and reads 64 after reset. A push to a full queue without a pop in the same cycle is dropped.
- R2: Bytes leave each queue in the order they entered. While a queue is not empty, its `*_rdata` output shows the oldest byte, and a pop removes it.
- R3: A pop from an empty queue leaves its count unchanged, and that queue's `*_rdata` reads 0x00. A push and a pop in the same cycle leave the count unchanged.
- R4: Control bits [7:6] are the coarse receive code. Codes 0, 1, 2 and 3 give thresholds of 8, 16, 56 and 60. `rx_trig` is 1 while the FIFOs are enabled and `rx_level` is at or above the threshold.
- R5: Control bits [5:4] are the coarse transmit code, with the same 8/16/56/60 mapping. `tx_trig` is 1 while the FIFOs are enabled and `tx_space` is at or above the threshold.
- R6: `fine_trig[7:4]` (receive) and `fine_trig[3:0]` (transmit) override the coarse code when nonzero. The threshold is then 4 times the field value, from 4 to 60.
- R7: A control write with bit 1 set empties the receive queue on that clock edge. Bit 2 does the same for the transmit queue. Neither command touches the other queue. Both bits always read back 0 in `ctrl_rdata`.
- R8: `data_ready` is 1 exactly when at least one byte is in the receive queue.
- R9: While `tx_disable` is 1, transmit pops are ignored, and host pushes still fill the transmit queue up to 64 bytes.
- R10: A receive push that is dropped because the queue is full sets the sticky `overrun` flag. A `status_rd` strobe clears it one cycle later. If a new overrun happens in the same cycle as `status_rd`, the flag stays set.
- R11: Control bit 0 enables the FIFOs and is 0 after reset. While it is 0, both queues are held empty, pushes are dropped, and both triggers are 0. A write that clears bit 0 empties both queues on that edge. Bit 3 is a spare bit that reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte: [7:6] rx code, [5:4] tx code, [3] spare, [2] tx flush, [1] rx flush, [0] enable |
| ctrl_rdata | output | 8 | Control byte readback, flush bits read 0 |
| fine_trig | input | 8 | Fine trigger fields: [7:4] receive, [3:0] transmit |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Host reads a received byte |
| rx_rdata | output | 8 | Oldest received byte, 0 when empty |
| tx_push | input | 1 | Host writes a byte to send |
| tx_wdata | input | 8 | Byte to send |
| tx_pop | input | 1 | Serializer takes a byte |
| tx_rdata | output | 8 | Oldest byte to send, 0 when empty |
| tx_disable | input | 1 | Freeze transmit draining |
| status_rd | input | 1 | Status read strobe, clears overrun |
| rx_level | output | 7 | Stored receive bytes |
| tx_space | output | 7 | Free transmit spaces |
| rx_trig | output | 1 | Receive trigger flag |
| tx_trig | output | 1 | Transmit trigger flag |
| data_ready | output | 1 | Receive queue not empty |
| overrun | output | 1 | Sticky receive overrun flag |

## Verification
The assertions check the following on every cycle:
- both level outputs stay within 0 to 64;
- an accepted receive push raises the count by exactly one;
- an empty queue reads zero;
- flush commands and disabling empty the queues on the next edge;
- a frozen transmitter keeps its free-space count;
- a full-queue push sets overrun;
- `data_ready` tracks the receive count.

Threshold selection is covered only by the bench scenarios. The bench sweeps every coarse code and every fine value against every fill level from 0 to 64. The bench scenarios also cover first-in first-out ordering, the independence of the two flushes, and the priority of a new overrun over a clearing status read.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    // Control byte as stored; flush bits are commands and are not kept
    typedef struct packed {
        logic [1:0] rx_code;
        logic [1:0] tx_code;
        logic       spare;
        logic       fifo_en;
        logic       overrun;
    } lvl_ctl_t;

    // Coarse trigger table shared by both directions
    function automatic logic [6:0] coarse_level(input logic [1:0] code);
        logic [6:0] lvl;
        case (code)
            2'd0:    lvl = 7'd8;
            2'd1:    lvl = 7'd16;
            2'd2:    lvl = 7'd56;
            default: lvl = 7'd60;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [CW-1:0] count,
    output logic [DW-1:0] head
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_inc, rd_inc;
    logic          empty, full, do_pop, do_push;

    // Pointer advance: free wrap for power-of-two depths, compare otherwise
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_inc = st_q.wr + 1'b1;
            assign rd_inc = st_q.rd + 1'b1;
        end else begin : g_wrap
            assign wr_inc = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
            assign rd_inc = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
    endgenerate

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CW'(DEPTH));
    assign do_pop  = pop && !empty && !clear;
    // A full queue still accepts a byte when the same cycle frees a slot
    assign do_push = push && !clear && (!full || do_pop);

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = wr_inc;
            if (do_pop)  st_d.rd = rd_inc;
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= wdata;
    end

    assign count = st_q.cnt;
    assign head  = empty ? '0 : mem_q[st_q.rd];

endmodule

// File: rtl/uart_trig_select.sv
module uart_trig_select #(
    parameter int CW = 7
) (
    input  logic          enable,
    input  logic [1:0]    code,
    input  logic [3:0]    fine,
    input  logic [CW-1:0] level,
    output logic          trig
);
    import uart_fifo_pkg::*;

    logic [CW-1:0] thr;

    // Nonzero fine field wins, in steps of four
    always_comb begin
        if (fine != 4'd0) thr = CW'({fine, 2'b00});
        else              thr = CW'(coarse_level(code));
    end

    assign trig = enable && (level >= thr);

endmodule

// File: rtl/uart_fifo_levels.sv
module uart_fifo_levels #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [7:0]    ctrl_wdata,
    output logic [7:0]    ctrl_rdata,
    input  logic [7:0]    fine_trig,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_wdata,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_rdata,
    input  logic          tx_disable,
    input  logic          status_rd,
    output logic [6:0]    rx_level,
    output logic [6:0]    tx_space,
    output logic          rx_trig,
    output logic          tx_trig,
    output logic          data_ready,
    output logic          overrun
);
    import uart_fifo_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    lvl_ctl_t      ctl_d, ctl_q;
    logic [CW-1:0] rx_cnt, tx_cnt;
    logic          rx_clear, tx_clear, off_cmd;
    logic          rx_push_g, rx_pop_g, tx_push_g, tx_pop_g, rx_drop;

    // Writing enable=0 flushes both queues on the same edge
    assign off_cmd   = ctrl_wr && !ctrl_wdata[0];
    assign rx_clear  = !ctl_q.fifo_en || off_cmd || (ctrl_wr && ctrl_wdata[1]);
    assign tx_clear  = !ctl_q.fifo_en || off_cmd || (ctrl_wr && ctrl_wdata[2]);

    assign rx_push_g = rx_push && ctl_q.fifo_en;
    assign rx_pop_g  = rx_pop  && ctl_q.fifo_en;
    assign tx_push_g = tx_push && ctl_q.fifo_en;
    assign tx_pop_g  = tx_pop  && ctl_q.fifo_en && !tx_disable;

    assign rx_drop   = rx_push_g && !rx_clear && (rx_cnt == CW'(DEPTH))
                       && !(rx_pop_g && rx_cnt != '0);

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_wr) begin
            ctl_d.rx_code = ctrl_wdata[7:6];
            ctl_d.tx_code = ctrl_wdata[5:4];
            ctl_d.spare   = ctrl_wdata[3];
            ctl_d.fifo_en = ctrl_wdata[0];
        end
        // A fresh loss outranks the clearing read
        if (rx_drop)        ctl_d.overrun = 1'b1;
        else if (status_rd) ctl_d.overrun = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) i_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rx_clear),
        .push  (rx_push_g),
        .wdata (rx_wdata),
        .pop   (rx_pop_g),
        .count (rx_cnt),
        .head  (rx_rdata)
    );

    uart_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) i_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tx_clear),
        .push  (tx_push_g),
        .wdata (tx_wdata),
        .pop   (tx_pop_g),
        .count (tx_cnt),
        .head  (tx_rdata)
    );

    logic [CW-1:0] tx_free;
    assign tx_free = CW'(DEPTH) - tx_cnt;

    uart_trig_select #(.CW(CW)) i_rx_trig (
        .enable (ctl_q.fifo_en),
        .code   (ctl_q.rx_code),
        .fine   (fine_trig[7:4]),
        .level  (rx_cnt),
        .trig   (rx_trig)
    );

    uart_trig_select #(.CW(CW)) i_tx_trig (
        .enable (ctl_q.fifo_en),
        .code   (ctl_q.tx_code),
        .fine   (fine_trig[3:0]),
        .level  (tx_free),
        .trig   (tx_trig)
    );

    assign rx_level   = 7'(rx_cnt);
    assign tx_space   = 7'(tx_free);
    assign data_ready = (rx_cnt != '0);
    assign overrun    = ctl_q.overrun;
    assign ctrl_rdata = {ctl_q.rx_code, ctl_q.tx_code, ctl_q.spare, 2'b00, ctl_q.fifo_en};

endmodule

// File: rtl/uart_fifo_levels_chk.sv
module uart_fifo_levels_chk #(
    parameter int DEPTH = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_wr,
    input logic [7:0] ctrl_wdata,
    input logic [7:0] ctrl_rdata,
    input logic       rx_push,
    input logic       rx_pop,
    input logic [7:0] rx_rdata,
    input logic       tx_push,
    input logic       tx_disable,
    input logic [6:0] rx_level,
    input logic [6:0] tx_space,
    input logic       rx_trig,
    input logic       tx_trig,
    input logic       data_ready,
    input logic       overrun
);
    logic en, rx_flush_req;
    assign en           = ctrl_rdata[0];
    assign rx_flush_req = ctrl_wr && (ctrl_wdata[1] || !ctrl_wdata[0]);

    a_r1_level_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= 7'(DEPTH)) && (tx_space <= 7'(DEPTH)));

    a_r1_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
        en && rx_push && !rx_pop && rx_level < 7'(DEPTH) && !rx_flush_req
        |=> rx_level == $past(rx_level) + 7'd1);

    a_r3_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level == 7'd0 |-> rx_rdata == 8'd0);

    a_r4_rx_trig_floor: assert property (@(posedge clk) disable iff (!rst_n)
        rx_trig |-> rx_level >= 7'd4);

    a_r5_tx_trig_floor: assert property (@(posedge clk) disable iff (!rst_n)
        tx_trig |-> tx_space >= 7'd4);

    a_r7_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && ctrl_wdata[1] |=> rx_level == 7'd0);

    a_r8_data_ready: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready == (rx_level != 7'd0));

    a_r9_tx_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        en && tx_disable && !tx_push && !ctrl_wr |=> $stable(tx_space));

    a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        en && rx_push && !rx_pop && rx_level == 7'(DEPTH) && !rx_flush_req |=> overrun);

    a_r11_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> rx_level == 7'd0 && tx_space == 7'(DEPTH) && !rx_trig && !tx_trig);

endmodule

bind uart_fifo_levels uart_fifo_levels_chk #(.DEPTH(DEPTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .rx_push    (rx_push),
    .rx_pop     (rx_pop),
    .rx_rdata   (rx_rdata),
    .tx_push    (tx_push),
    .tx_disable (tx_disable),
    .rx_level   (rx_level),
    .tx_space   (tx_space),
    .rx_trig    (rx_trig),
    .tx_trig    (tx_trig),
    .data_ready (data_ready),
    .overrun    (overrun)
);

// File: tb/test_uart_fifo_levels.sv
module test_uart_fifo_levels;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = 8'd0;
    logic [7:0] ctrl_rdata;
    logic [7:0] fine_trig = 8'd0;
    logic       rx_push = 1'b0, rx_pop = 1'b0, tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] rx_wdata = 8'd0, tx_wdata = 8'd0, rx_rdata, tx_rdata;
    logic       tx_disable = 1'b0, status_rd = 1'b0;
    logic [6:0] rx_level, tx_space;
    logic       rx_trig, tx_trig, data_ready, overrun;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_fifo_levels i_uart_fifo_levels (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .fine_trig(fine_trig),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_disable(tx_disable), .status_rd(status_rd),
        .rx_level(rx_level), .tx_space(tx_space), .rx_trig(rx_trig), .tx_trig(tx_trig),
        .data_ready(data_ready), .overrun(overrun)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int thr_of(input int code, input int fine);
        if (fine != 0) return 4 * fine;
        case (code)
            0: return 8;
            1: return 16;
            2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic logic [7:0] pat(input int n, input int sel);
        return 8'(n * 7 + sel * 13 + 1);
    endfunction

    task automatic cfg(input logic [1:0] rxc, input logic [1:0] txc,
                       input logic rrst, input logic trst);
        ctrl_wr = 1'b1;
        ctrl_wdata = {rxc, txc, 1'b0, trst, rrst, 1'b1};
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_push = 1'b1; rx_wdata = b; tick(); rx_push = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_push = 1'b1; tx_wdata = b; tick(); tx_push = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // Reset state
        chk_eq("R1 rx level after reset", rx_level, 0);
        chk_eq("R1 tx space after reset", tx_space, 64);
        chk_eq("R8 data_ready after reset", data_ready, 0);
        chk_eq("R11 enable after reset", ctrl_rdata, 0);
        chk_eq("R11 triggers low while disabled", {rx_trig, tx_trig}, 0);
        chk_eq("R10 overrun after reset", overrun, 0);
        push_rx(8'h5A);
        chk_eq("R11 push dropped while disabled", rx_level, 0);

        // Receive sweeps: 4 coarse codes then fine values 1..15
        for (int sel = 0; sel < 19; sel++) begin
            int code = (sel < 4) ? sel : 0;
            int fine = (sel < 4) ? 0 : sel - 3;
            int t = thr_of(code, fine);
            fine_trig = {4'(fine), 4'd0};
            cfg(2'(code), 2'd0, 1'b1, 1'b0);
            chk_eq("R7 rx flush", rx_level, 0);
            for (int n = 1; n <= 64; n++) begin
                push_rx(pat(n, sel));
                chk_eq("R1 rx level", rx_level, n);
                chk_eq(sel < 4 ? "R4 rx coarse trigger" : "R6 rx fine trigger",
                       rx_trig, int'(n >= t));
                if (n == 1) chk_eq("R8 data_ready set", data_ready, 1);
            end
            push_rx(8'hEE);
            chk_eq("R1 rx full drop", rx_level, 64);
            chk_eq("R10 overrun set", overrun, 1);
            status_rd = 1'b1; tick(); status_rd = 1'b0;
            chk_eq("R10 overrun cleared", overrun, 0);
            for (int n = 1; n <= 64; n++) begin
                chk_eq("R2 rx order", rx_rdata, pat(n, sel));
                rx_pop = 1'b1; tick(); rx_pop = 1'b0;
            end
            chk_eq("R8 data_ready clear", data_ready, 0);
            rx_pop = 1'b1; tick(); rx_pop = 1'b0;
            chk_eq("R3 empty pop count", rx_level, 0);
            chk_eq("R3 empty pop data", rx_rdata, 0);
        end
        fine_trig = 8'd0;

        // Transmit sweeps with the transmitter frozen
        for (int sel = 0; sel < 19; sel++) begin
            int code = (sel < 4) ? sel : 0;
            int fine = (sel < 4) ? 0 : sel - 3;
            int t = thr_of(code, fine);
            fine_trig = {4'd0, 4'(fine)};
            cfg(2'd0, 2'(code), 1'b0, 1'b1);
            chk_eq("R7 tx flush", tx_space, 64);
            chk_eq(sel < 4 ? "R5 tx coarse trigger" : "R6 tx fine trigger", tx_trig, 1);
            tx_disable = 1'b1;
            tx_pop = 1'b1;
            for (int n = 1; n <= 64; n++) begin
                push_tx(pat(n, sel));
                chk_eq("R9 tx fills while disabled", tx_space, 64 - n);
                chk_eq(sel < 4 ? "R5 tx coarse trigger" : "R6 tx fine trigger",
                       tx_trig, int'((64 - n) >= t));
            end
            push_tx(8'hEE);
            chk_eq("R1 tx full drop", tx_space, 0);
            tx_pop = 1'b0;
            tx_disable = 1'b0;
            for (int n = 1; n <= 64; n++) begin
                chk_eq("R2 tx order", tx_rdata, pat(n, sel));
                tx_pop = 1'b1; tick(); tx_pop = 1'b0;
            end
            chk_eq("R1 tx drained", tx_space, 64);
            chk_eq("R3 tx empty data", tx_rdata, 0);
        end
        fine_trig = 8'd0;

        // Simultaneous push and pop
        cfg(2'd0, 2'd0, 1'b1, 1'b1);
        push_rx(8'd10); push_rx(8'd11); push_rx(8'd12);
        rx_push = 1'b1; rx_pop = 1'b1; rx_wdata = 8'd13; tick();
        rx_push = 1'b0; rx_pop = 1'b0;
        chk_eq("R3 push+pop count", rx_level, 3);
        chk_eq("R3 push+pop head", rx_rdata, 11);

        // Flush independence and readback
        tx_disable = 1'b1;
        for (int n = 0; n < 5; n++) push_tx(8'(n));
        cfg(2'd2, 2'd1, 1'b1, 1'b0);
        chk_eq("R7 rx flushed", rx_level, 0);
        chk_eq("R7 tx untouched", tx_space, 59);
        chk_eq("R7 flush bits read 0", ctrl_rdata, 8'h91);
        cfg(2'd2, 2'd1, 1'b0, 1'b1);
        chk_eq("R7 tx flushed", tx_space, 64);
        tx_disable = 1'b0;
        ctrl_wr = 1'b1; ctrl_wdata = 8'h09; tick(); ctrl_wr = 1'b0;
        chk_eq("R11 spare bit readback", ctrl_rdata, 8'h09);

        // Overrun outranks a clearing status read
        cfg(2'd0, 2'd0, 1'b1, 1'b1);
        for (int n = 0; n < 64; n++) push_rx(8'(n));
        rx_push = 1'b1; status_rd = 1'b1; tick(); rx_push = 1'b0; status_rd = 1'b0;
        chk_eq("R10 set wins over read", overrun, 1);
        status_rd = 1'b1; tick(); status_rd = 1'b0;
        chk_eq("R10 cleared by read", overrun, 0);

        // Disable flushes both queues
        push_tx(8'h33);
        ctrl_wr = 1'b1; ctrl_wdata = 8'h00; tick(); ctrl_wr = 1'b0;
        chk_eq("R11 rx emptied on disable", rx_level, 0);
        chk_eq("R11 tx emptied on disable", tx_space, 64);
        chk_eq("R11 triggers low", {rx_trig, tx_trig}, 0);
        chk_eq("R11 rdata zero", rx_rdata, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule